// File: doc/BRIEF.md
# Closed Caption Line Encoder

This block produces the luminance sample stream that carries closed caption or extended data service bytes on one chosen video line per field. A host loads two 7-bit characters for each of the two fields and, optionally, a new target line number through a write-strobe register port. The video timing logic supplies a one-cycle strobe at the first sample of every line, a second strobe marking the first line of a field, and the field identity.

On the target line, after a fixed sample delay, the block sends seven run-in clock cycles, a three-bit start code and the two characters. Each character goes out least significant bit first and is followed by an odd parity bit that the block computes itself. Bit timing is 32 bits per line period. A fractional phase accumulator derives it from the sample clock, with the line length chosen by a 60 Hz / 50 Hz rate select. Outside the burst the output sits at the blanking code. If a field's characters were not rewritten since they were last sent, the block sends the null pair instead.

Top module: `cc_line_encoder`

## Requirements
- R1: After reset `level_o` equals the blank code (240), `active_o` is low, and the target line is 21.
- R2: A burst is sent only on the line whose number (the line carrying `field_strobe_i` is line 1) equals the target line. Every other line stays at the blank code with `active_o` low.
- R3: The burst begins START_DLY samples after the target line's strobe cycle with seven run-in cycles. Each cycle has a high half followed by a low half.
- R4: After the run-in come the start bits 0, 0, 1. Then comes the first character, 7 data bits least significant first, then its odd parity bit. The second character follows in the same form, for 26 bits in total.
- R5: Sample j of the burst (j = 0 at the first run-in sample) belongs to half-bit floor(j*64/L), where L is the line length in samples. The burst ends after half-bit 51. `active_o` is high exactly during the burst.
- R6: A 1 bit (and a run-in high half) drives the high code (560). A 0 bit drives the blank code (240).
- R7: Field 0 (`field_id_i`=0) sends the characters at addresses 0 and 1. Field 1 sends those at addresses 2 and 3. The first address of each pair goes out first.
- R8: If neither character of a field was written since that field's last burst, the burst carries data 0 with parity 1 for both characters.
- R9: Bit 7 of a character write has no effect; parity always comes from bits 6:0.
- R10: A write to address 4 sets the target line only if the value lies in 10..25. Other values are ignored.
- R11: `rate_50hz_i`=1 selects the 50 Hz line length (default 1728 samples) in place of the 60 Hz one (default 1716) for the bit timing of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0..3 characters, 4 target line |
| wr_data_i | input | 8 | Write data |
| line_strobe_i | input | 1 | High for the first sample of each line |
| field_strobe_i | input | 1 | High with the line strobe on a field's first line |
| field_id_i | input | 1 | Field identity, sampled with `field_strobe_i` |
| rate_50hz_i | input | 1 | 1 selects 50 Hz line length, sampled at the target line strobe |
| level_o | output | 10 | Luminance sample code |
| active_o | output | 1 | High while the burst is being sent |

## Verification
A wrong line count or a wrongly captured field identity shows up on the same line as a burst placed on the wrong line or carrying the other field's characters. A wrong phase accumulator or half-bit index makes the bit edges of the waveform drift by whole samples within a few bits. It also moves the falling edge of `active_o`. A stale freshness flag appears one field later, as a null pair where data was expected or a repeated pair where a null was expected. Each burst is compared sample by sample against a waveform computed from the requirements.

// File: rtl/cc_enc_pkg.sv
package cc_enc_pkg;

   localparam int unsigned FIELDS       = 2;
   localparam int unsigned RUNIN_BITS   = 7;
   localparam int unsigned FRAME_BITS   = 26;
   localparam int unsigned FRAME_HALVES = 2 * FRAME_BITS;
   localparam int unsigned HALF_W       = 6;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SEND = 2'd2
   } cc_state_t;

   // character plus odd parity in bit 7
   function automatic logic [7:0] cc_code(input logic [6:0] ch);
      return {~^ch, ch};
   endfunction

endpackage

// File: rtl/cc_reg_file.sv
module cc_reg_file #(
   parameter int unsigned LINE_W       = 10,
   parameter int unsigned LINE_MIN     = 10,
   parameter int unsigned LINE_MAX     = 25,
   parameter int unsigned LINE_DEFAULT = 21
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en_i,
   input  logic [2:0]             wr_addr_i,
   input  logic [7:0]             wr_data_i,
   input  logic                   take_i,
   input  logic                   take_field_i,
   output logic [1:0][1:0][6:0]   chars_o,
   output logic [1:0]             fresh_o,
   output logic [LINE_W-1:0]      target_o
);

   localparam logic [2:0] ADDR_LINE = 3'd4;

   logic [LINE_W-1:0] wr_line;
   logic              line_ok;

   assign wr_line = LINE_W'(wr_data_i);
   assign line_ok = (wr_line >= LINE_W'(LINE_MIN)) && (wr_line <= LINE_W'(LINE_MAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target_o <= LINE_W'(LINE_DEFAULT);
      end else if (wr_en_i && (wr_addr_i == ADDR_LINE) && line_ok) begin
         target_o <= wr_line;
      end
   end

   for (genvar f = 0; f < 2; f++) begin : g_field
      localparam logic [2:0] A_LO = 3'(2 * f);
      localparam logic [2:0] A_HI = 3'(2 * f + 1);

      logic hit_lo, hit_hi, taken;

      assign hit_lo = wr_en_i && (wr_addr_i == A_LO);
      assign hit_hi = wr_en_i && (wr_addr_i == A_HI);
      assign taken  = take_i && (take_field_i == 1'(f));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chars_o[f] <= '0;
            fresh_o[f] <= 1'b0;
         end else begin
            if (hit_lo) chars_o[f][0] <= wr_data_i[6:0];
            if (hit_hi) chars_o[f][1] <= wr_data_i[6:0];
            if (hit_lo || hit_hi) fresh_o[f] <= 1'b1;
            else if (taken)       fresh_o[f] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cc_line_timer.sv
module cc_line_timer #(
   parameter int unsigned LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_strobe_i,
   input  logic              field_strobe_i,
   input  logic              field_id_i,
   input  logic [LINE_W-1:0] target_i,
   output logic              hit_o,
   output logic              hit_field_o
);

   logic [LINE_W-1:0] line_q;
   logic [LINE_W-1:0] line_nxt;
   logic              field_q;

   assign line_nxt    = field_strobe_i ? LINE_W'(1) : line_q + LINE_W'(1);
   assign hit_o       = line_strobe_i && (line_nxt == target_i);
   assign hit_field_o = field_strobe_i ? field_id_i : field_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= '0;
         field_q <= 1'b0;
      end else if (line_strobe_i) begin
         line_q  <= line_nxt;
         field_q <= hit_field_o;
      end
   end

endmodule

// File: rtl/cc_half_tick.sv
module cc_half_tick #(
   parameter int unsigned LINE_60       = 1716,
   parameter int unsigned LINE_50       = 1728,
   parameter int unsigned BITS_PER_LINE = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic sel50_i,
   output logic tick_o
);

   localparam int unsigned STEP     = 2 * BITS_PER_LINE;
   localparam int unsigned LINE_TOP = (LINE_60 > LINE_50) ? LINE_60 : LINE_50;
   localparam int unsigned ACC_W    = $clog2(LINE_TOP + STEP + 1);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;
   logic [ACC_W-1:0] modulus;

   if (LINE_60 == LINE_50) begin : g_single_rate
      assign modulus = ACC_W'(LINE_60);
      logic unused_sel;
      assign unused_sel = sel50_i;
   end else begin : g_dual_rate
      assign modulus = sel50_i ? ACC_W'(LINE_50) : ACC_W'(LINE_60);
   end

   assign sum    = acc_q + ACC_W'(STEP);
   assign tick_o = run_i && (sum >= modulus);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (!run_i)  acc_q <= '0;
      else if (tick_o)  acc_q <= sum - modulus;
      else              acc_q <= sum;
   end

endmodule

// File: rtl/cc_serializer.sv
module cc_serializer
   import cc_enc_pkg::*;
#(
   parameter int unsigned START_DLY = 283,
   parameter int unsigned LVL_W     = 10,
   parameter int unsigned LVL_BLANK = 240,
   parameter int unsigned LVL_HIGH  = 560
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_i,
   input  logic [7:0]       code0_i,
   input  logic [7:0]       code1_i,
   input  logic             tick_i,
   output logic             run_o,
   output logic [LVL_W-1:0] level_o,
   output logic             active_o
);

   localparam int unsigned DLY_W = $clog2(START_DLY + 1);

   cc_state_t               state_q;
   logic [DLY_W-1:0]        dly_q;
   logic [HALF_W-1:0]       half_q;
   logic [FRAME_BITS-1:0]   frame_q;
   logic [4:0]              bit_idx;
   logic                    bit_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dly_q   <= '0;
         half_q  <= '0;
         frame_q <= '0;
      end else if (hit_i) begin
         state_q <= ST_WAIT;
         dly_q   <= '0;
         half_q  <= '0;
         frame_q <= {code1_i, code0_i, 3'b100, 7'b0};
      end else begin
         case (state_q)
            ST_WAIT: begin
               if (dly_q == DLY_W'(START_DLY - 1)) state_q <= ST_SEND;
               else                                 dly_q   <= dly_q + DLY_W'(1);
            end
            ST_SEND: begin
               if (tick_i) begin
                  if (half_q == HALF_W'(FRAME_HALVES - 1)) state_q <= ST_IDLE;
                  else                                     half_q  <= half_q + HALF_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bit_idx  = half_q[HALF_W-1:1];
   assign bit_val  = (bit_idx < 5'(RUNIN_BITS)) ? ~half_q[0] : frame_q[bit_idx];
   assign run_o    = (state_q == ST_SEND);
   assign active_o = run_o;
   assign level_o  = (run_o && bit_val) ? LVL_W'(LVL_HIGH) : LVL_W'(LVL_BLANK);

endmodule

// File: rtl/cc_line_encoder.sv
module cc_line_encoder
   import cc_enc_pkg::*;
#(
   parameter int unsigned LINE_60       = 1716,
   parameter int unsigned LINE_50       = 1728,
   parameter int unsigned BITS_PER_LINE = 32,
   parameter int unsigned START_DLY     = 283,
   parameter int unsigned LINE_W        = 10,
   parameter int unsigned LINE_MIN      = 10,
   parameter int unsigned LINE_MAX      = 25,
   parameter int unsigned LINE_DEFAULT  = 21,
   parameter int unsigned LVL_W         = 10,
   parameter int unsigned LVL_BLANK     = 240,
   parameter int unsigned LVL_HIGH      = 560
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_addr_i,
   input  logic [7:0]       wr_data_i,
   input  logic             line_strobe_i,
   input  logic             field_strobe_i,
   input  logic             field_id_i,
   input  logic             rate_50hz_i,
   output logic [LVL_W-1:0] level_o,
   output logic             active_o
);

   localparam int unsigned STEP      = 2 * BITS_PER_LINE;
   localparam int unsigned SPAN_60   = (FRAME_HALVES * LINE_60 + STEP - 1) / STEP;
   localparam int unsigned SPAN_50   = (FRAME_HALVES * LINE_50 + STEP - 1) / STEP;
   localparam int unsigned LINE_LOW  = (LINE_60 < LINE_50) ? LINE_60 : LINE_50;

   if (START_DLY < 1) begin : g_bad_dly
      $error("start delay must be at least one sample");
   end
   if (STEP >= LINE_LOW) begin : g_bad_step
      $error("bit rate too high for the line length");
   end
   if ((START_DLY + SPAN_60 >= LINE_60) || (START_DLY + SPAN_50 >= LINE_50)) begin : g_bad_fit
      $error("burst does not fit inside one line");
   end
   if ((LINE_W < 8) || (LINE_MIN < 1) || (LINE_MAX > 255) || (LINE_MIN > LINE_MAX)) begin : g_bad_range
      $error("line range or width invalid");
   end
   if ((LINE_DEFAULT < LINE_MIN) || (LINE_DEFAULT > LINE_MAX)) begin : g_bad_default
      $error("default line outside the allowed range");
   end
   if ((LVL_HIGH >= (1 << LVL_W)) || (LVL_BLANK >= LVL_HIGH)) begin : g_bad_level
      $error("level codes invalid");
   end

   logic [1:0][1:0][6:0] chars;
   logic [1:0]           fresh;
   logic [LINE_W-1:0]    target_line;
   logic                 hit, hit_field;
   logic [6:0]           ch0, ch1;
   logic                 run, tick;
   logic                 sel50_q;

   cc_reg_file #(
      .LINE_W(LINE_W), .LINE_MIN(LINE_MIN), .LINE_MAX(LINE_MAX), .LINE_DEFAULT(LINE_DEFAULT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .take_i(hit), .take_field_i(hit_field),
      .chars_o(chars), .fresh_o(fresh), .target_o(target_line)
   );

   cc_line_timer #(.LINE_W(LINE_W)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .line_strobe_i(line_strobe_i), .field_strobe_i(field_strobe_i),
      .field_id_i(field_id_i), .target_i(target_line),
      .hit_o(hit), .hit_field_o(hit_field)
   );

   assign ch0 = fresh[hit_field] ? chars[hit_field][0] : 7'd0;
   assign ch1 = fresh[hit_field] ? chars[hit_field][1] : 7'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sel50_q <= 1'b0;
      else if (hit) sel50_q <= rate_50hz_i;
   end

   cc_half_tick #(
      .LINE_60(LINE_60), .LINE_50(LINE_50), .BITS_PER_LINE(BITS_PER_LINE)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .run_i(run), .sel50_i(sel50_q), .tick_o(tick)
   );

   cc_serializer #(
      .START_DLY(START_DLY), .LVL_W(LVL_W), .LVL_BLANK(LVL_BLANK), .LVL_HIGH(LVL_HIGH)
   ) u_ser (
      .clk(clk), .rst_n(rst_n), .hit_i(hit),
      .code0_i(cc_code(ch0)), .code1_i(cc_code(ch1)),
      .tick_i(tick), .run_o(run), .level_o(level_o), .active_o(active_o)
   );

endmodule

// File: rtl/cc_line_encoder_chk.sv
module cc_line_encoder_chk #(
   parameter int unsigned LINE_W    = 10,
   parameter int unsigned LINE_MIN  = 10,
   parameter int unsigned LINE_MAX  = 25,
   parameter int unsigned LVL_W     = 10,
   parameter int unsigned LVL_BLANK = 240,
   parameter int unsigned LVL_HIGH  = 560
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_strobe_i,
   input logic [LVL_W-1:0]  level_o,
   input logic              active_o,
   input logic [LINE_W-1:0] target_line
);

   // R6: outside the burst the output rests at blank
   p_idle_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !active_o |-> level_o == LVL_W'(LVL_BLANK));

   // R6: only the two level codes ever appear
   p_two_levels_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o == LVL_W'(LVL_BLANK)) || (level_o == LVL_W'(LVL_HIGH)));

   // R3: the burst opens with the high half of the run-in
   p_runin_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_o) |-> level_o == LVL_W'(LVL_HIGH));

   // R5: a burst never spills into the next line
   p_fits_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      line_strobe_i |-> !active_o);

   // R10: the target line stays within its allowed range
   p_target_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (target_line >= LINE_W'(LINE_MIN)) && (target_line <= LINE_W'(LINE_MAX)));

endmodule

bind cc_line_encoder cc_line_encoder_chk #(
   .LINE_W(LINE_W), .LINE_MIN(LINE_MIN), .LINE_MAX(LINE_MAX),
   .LVL_W(LVL_W), .LVL_BLANK(LVL_BLANK), .LVL_HIGH(LVL_HIGH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .line_strobe_i(line_strobe_i),
   .level_o(level_o), .active_o(active_o), .target_line(target_line)
);

// File: tb/cc_line_encoder_bench.sv
`timescale 1ns/1ps
module cc_line_encoder_bench;

   localparam int L60   = 136;
   localparam int L50   = 160;
   localparam int DLY   = 8;
   localparam int BLANK = 240;
   localparam int HIGH  = 560;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       line_stb = 1'b0;
   logic       field_stb = 1'b0;
   logic       field_id = 1'b0;
   logic       rate50 = 1'b0;
   logic [9:0] level;
   logic       active;

   int checks = 0;
   int errors = 0;
   int tgt_model = 21;
   logic [6:0] chars_m [2][2];
   logic       fresh_m [2];

   always #2.5 clk = ~clk;

   cc_line_encoder #(
      .LINE_60(L60), .LINE_50(L50), .START_DLY(DLY)
   ) u_cc_line_encoder (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .line_strobe_i(line_stb), .field_strobe_i(field_stb), .field_id_i(field_id),
      .rate_50hz_i(rate50), .level_o(level), .active_o(active)
   );

   // vector: {field, rate50, write, pad, char0, char1}
   localparam int NV = 6;
   localparam logic [19:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b1, 1'b0, 8'h41, 8'h42},
      {1'b1, 1'b0, 1'b1, 1'b0, 8'h14, 8'h7F},
      {1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00},
      {1'b1, 1'b1, 1'b1, 1'b0, 8'hC5, 8'h00},
      {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00},
      {1'b0, 1'b1, 1'b1, 1'b0, 8'h55, 8'h2A}
   };

   function automatic int exp_level(input logic [6:0] d0, input logic [6:0] d1,
                                    input int m, input int len, output logic act);
      int j, h, b;
      logic [25:0] fr;
      logic v;
      act = 1'b0;
      if (m < DLY) return BLANK;
      j = m - DLY;
      h = (j * 64) / len;
      if (h >= 52) return BLANK;
      act = 1'b1;
      b = h / 2;
      fr = {~^d1, d1, ~^d0, d0, 3'b100, 7'b0};
      v = (b < 7) ? (h % 2 == 0) : fr[b];
      return v ? HIGH : BLANK;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      if (a < 3'd4) begin
         chars_m[a[1]][a[0]] = d[6:0];
         fresh_m[a[1]] = 1'b1;
      end else if (d >= 8'd10 && d <= 8'd25) begin
         tgt_model = int'(d);
      end
   endtask

   // runs one field of nlines lines, comparing every sample
   task automatic run_field(input logic fid, input logic r50, input int nlines, input string req);
      int len;
      len = r50 ? L50 : L60;
      rate50 = r50;
      for (int n = 1; n <= nlines; n++) begin
         logic [6:0] d0, d1;
         bit tgt, bad;
         int bad_act, bad_exp;
         tgt = (n == tgt_model);
         d0 = 7'd0; d1 = 7'd0;
         if (tgt && fresh_m[fid]) begin
            d0 = chars_m[fid][0]; d1 = chars_m[fid][1];
         end
         if (tgt) fresh_m[fid] = 1'b0;
         bad = 1'b0; bad_act = 0; bad_exp = 0;
         for (int m = 0; m < len; m++) begin
            int e;
            logic ea;
            line_stb  = (m == 0);
            field_stb = (m == 0) && (n == 1);
            field_id  = fid;
            @(posedge clk); @(negedge clk);
            if (tgt) e = exp_level(d0, d1, m, len, ea);
            else begin e = BLANK; ea = 1'b0; end
            if (!bad && ((int'(level) != e) || (active != ea))) begin
               bad = 1'b1; bad_act = int'(level) + 10000 * int'(active);
               bad_exp = e + 10000 * int'(ea);
            end
         end
         line_stb = 1'b0; field_stb = 1'b0;
         check(!bad, tgt ? req : "R2", bad_act, bad_exp);
      end
   endtask

   task automatic main_flow();
      fresh_m[0] = 1'b0; fresh_m[1] = 1'b0;
      for (int f = 0; f < 2; f++) begin
         chars_m[f][0] = '0; chars_m[f][1] = '0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      check(level == 10'd240, "R1", int'(level), BLANK);
      check(active == 1'b0, "R1", int'(active), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R3 R4 R5 R6 R8 R9 R11 on line 21
      for (int v = 0; v < NV; v++) begin
         logic [19:0] w;
         w = VEC[v];
         if (w[17]) begin
            write_reg({1'b0, w[19], 1'b0}, w[15:8]);
            write_reg({1'b0, w[19], 1'b1}, w[7:0]);
         end
         run_field(w[19], w[18], 21, w[18] ? "R11" : "R4");
      end

      // R7: per-field pairs, sent in reverse field order
      write_reg(3'd0, 8'h11);
      write_reg(3'd1, 8'h22);
      write_reg(3'd2, 8'h33);
      write_reg(3'd3, 8'h44);
      run_field(1'b1, 1'b0, 21, "R7");
      run_field(1'b0, 1'b0, 21, "R7");
      // R8: nothing new written, null pair follows
      run_field(1'b0, 1'b0, 21, "R8");

      // R10: out-of-range line ignored (stays 21), in-range taken
      write_reg(3'd4, 8'd5);
      write_reg(3'd0, 8'h7E);
      run_field(1'b0, 1'b0, 21, "R10");
      write_reg(3'd4, 8'd12);
      write_reg(3'd2, 8'h01);
      run_field(1'b1, 1'b0, 13, "R10");
      write_reg(3'd4, 8'd26);
      run_field(1'b1, 1'b1, 13, "R10");
      write_reg(3'd4, 8'd10);
      write_reg(3'd1, 8'h80);
      run_field(1'b0, 1'b1, 11, "R10");
   endtask

   initial begin
      fork
         main_flow();
         begin
            repeat (190000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule